// File: doc/BRIEF.md
# ASCII Command Token Interpreter

This block connects a byte-wide host link to a capture engine. Every host command is a single printable ASCII character. The block turns each command into a control strobe, a one-character status reply, an identification string or a dump of the capture memory. Input and output bytes both use a valid/ready handshake. The input side never back-pressures.

A dump reads the stored records from address zero up to the write count minus one, one at a time, through a synchronous read port. Each record can be sent in one of two forms:

- raw binary, as four bytes with the most significant byte first;
- ASCII text, as eight uppercase hexadecimal digits followed by a line feed.

While a reply or a dump is being sent, incoming bytes are consumed and dropped. Output bytes stay frozen while the sink stalls.

Top module: `tokcmd_ctrl`

## Requirements
- R1: An accepted byte 0x67 ('g'), 0x73 ('s') or 0x72 ('r') in the idle state raises `ctl_start`, `ctl_stop` or `ctl_reset` respectively. The strobe is high for exactly one cycle, the cycle after acceptance, and no other strobe rises with it.
- R2: An accepted byte 0x53 ('S') produces one reply byte. The reply is 0x66 ('f') if `cap_full` is high, else 0x72 ('r') if `cap_running` is high, else 0x73 ('s').
- R3: An accepted byte 0x69 ('i') produces the five bytes 0x43 0x54 0x49 0x31 0x0A ("CTI1" and a line feed), in that order.
- R4: An accepted byte 0x64 ('d') with a nonzero `wr_count` sends, for each address from 0 to `wr_count`-1 in ascending order, the 32-bit record as four bytes, bits 31:24 first and bits 7:0 last.
- R5: An accepted byte 0x44 ('D') sends each record of the same address range as eight ASCII hex digits, followed by 0x0A.
  - The digits run from bits 31:28 down to bits 3:0.
  - Values 0-9 map to 0x30-0x39 and values 10-15 map to 0x41-0x46.
- R6: The read port behaves as follows during a dump:
  - Exactly one read is issued per record, at ascending addresses, and no read address reaches the latched count.
  - Read data is taken the cycle after `mem_rd_en`.
  - A dump command with `wr_count` equal to zero sends nothing and issues no read.
- R7: Any byte other than the seven command bytes is ignored: it produces no output byte, no strobe and no read.
- R8: Bytes that arrive while a reply or dump is in progress are discarded.
  - `host_in_ready` stays high throughout.
  - Commands are decoded again once the output is finished.
- R9: Output bytes are held stable while the sink stalls:
  - While `host_out_valid` is high and `host_out_ready` is low, `host_out_valid` and `host_out_data` hold in the next cycle.
  - No byte is lost or duplicated under any ready pattern.
- R10: After reset no output is valid, no strobe is high, no read is issued and `host_in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_in_valid | input | 1 | Host byte present |
| host_in_data | input | 8 | Host command byte |
| host_in_ready | output | 1 | Block accepts a host byte (always high) |
| host_out_valid | output | 1 | Reply byte present |
| host_out_data | output | 8 | Reply byte |
| host_out_ready | input | 1 | Sink accepts the reply byte |
| cap_running | input | 1 | Capture engine is sampling |
| cap_full | input | 1 | Capture memory is full |
| ctl_start | output | 1 | One-cycle start strobe |
| ctl_stop | output | 1 | One-cycle stop strobe |
| ctl_reset | output | 1 | One-cycle capture reset strobe |
| wr_count | input | ADDR_W+1 | Number of stored records |
| mem_rd_en | output | 1 | Record read request |
| mem_rd_addr | output | ADDR_W | Record read address |
| mem_rd_data | input | REC_W | Record data, valid the cycle after the request |

## Verification
The hardest case to reach from the ports is a command byte arriving in the middle of a dump while the sink is stalling. In that case the byte must vanish without a strobe, without a reply and without disturbing the record stream. The bench reaches it by sending a start byte and a status byte directly behind every dump command. Each dump runs under one of three ready patterns (always ready, alternating, and an irregular stall pattern). The full byte stream is then compared with one computed from the record function. A sweep over all 249 non-command byte values covers the ignore rule.

// File: rtl/tokcmd_pkg.sv
package tokcmd_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_GO,
        CMD_HALT,
        CMD_CLR,
        CMD_DBIN,
        CMD_DHEX,
        CMD_IDENT,
        CMD_STAT
    } tok_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STAT,
        ST_IDENT,
        ST_FETCH,
        ST_LOAD,
        ST_EMIT
    } tok_state_e;

    // command characters
    localparam logic [7:0] CH_GO    = 8'h67;
    localparam logic [7:0] CH_HALT  = 8'h73;
    localparam logic [7:0] CH_CLR   = 8'h72;
    localparam logic [7:0] CH_DBIN  = 8'h64;
    localparam logic [7:0] CH_DHEX  = 8'h44;
    localparam logic [7:0] CH_IDENT = 8'h69;
    localparam logic [7:0] CH_STAT  = 8'h53;

    // reply characters
    localparam logic [7:0] RPL_RUN  = 8'h72;
    localparam logic [7:0] RPL_IDLE = 8'h73;
    localparam logic [7:0] RPL_FULL = 8'h66;
    localparam logic [7:0] CH_LF    = 8'h0A;

    // identification text "CTI1" followed by a line feed
    localparam int ID_LEN = 5;
    localparam logic [8*ID_LEN-1:0] ID_STR = {8'h43, 8'h54, 8'h49, 8'h31, CH_LF};

    function automatic logic [7:0] id_byte(input int pos);
        logic [7:0] b;
        b = CH_LF;
        for (int k = 0; k < ID_LEN; k++) begin
            if (pos == k) b = ID_STR[8*(ID_LEN-1-k) +: 8];
        end
        return b;
    endfunction

    function automatic logic [7:0] hex_char(input logic [3:0] nib);
        return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
    endfunction

endpackage

// File: rtl/tokcmd_decode.sv
module tokcmd_decode
    import tokcmd_pkg::*;
(
    input  logic [7:0] tok_i,
    output tok_cmd_e   cmd_o
);

    always_comb begin
        case (tok_i)
            CH_GO:    cmd_o = CMD_GO;
            CH_HALT:  cmd_o = CMD_HALT;
            CH_CLR:   cmd_o = CMD_CLR;
            CH_DBIN:  cmd_o = CMD_DBIN;
            CH_DHEX:  cmd_o = CMD_DHEX;
            CH_IDENT: cmd_o = CMD_IDENT;
            CH_STAT:  cmd_o = CMD_STAT;
            default:  cmd_o = CMD_NONE;
        endcase
    end

endmodule

// File: rtl/tokcmd_serial.sv
module tokcmd_serial
    import tokcmd_pkg::*;
#(
    parameter int REC_W = 32,
    parameter int IDX_W = 4
) (
    input  logic [REC_W-1:0] rec_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             hex_mode_i,
    output logic [7:0]       byte_o
);

    localparam int NBYTES = REC_W / 8;
    localparam int NNIB   = REC_W / 4;

    logic [7:0] bin_byte;
    logic [7:0] txt_byte;

    // raw form: byte k counted from the most significant end
    always_comb begin
        bin_byte = 8'h00;
        for (int k = 0; k < NBYTES; k++) begin
            if (idx_i == IDX_W'(k)) bin_byte = rec_i[REC_W-8-8*k +: 8];
        end
    end

    // text form: nibble k from the top, then a line feed at index NNIB
    always_comb begin
        txt_byte = CH_LF;
        for (int k = 0; k < NNIB; k++) begin
            if (idx_i == IDX_W'(k)) txt_byte = hex_char(rec_i[REC_W-4-4*k +: 4]);
        end
    end

    assign byte_o = hex_mode_i ? txt_byte : bin_byte;

endmodule

// File: rtl/tokcmd_ctrl.sv
module tokcmd_ctrl
    import tokcmd_pkg::*;
#(
    parameter int REC_W  = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_in_valid,
    input  logic [7:0]        host_in_data,
    output logic              host_in_ready,
    output logic              host_out_valid,
    output logic [7:0]        host_out_data,
    input  logic              host_out_ready,
    input  logic              cap_running,
    input  logic              cap_full,
    output logic              ctl_start,
    output logic              ctl_stop,
    output logic              ctl_reset,
    input  logic [ADDR_W:0]   wr_count,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [REC_W-1:0]  mem_rd_data
);

    localparam int NBYTES  = REC_W / 8;
    localparam int NNIB    = REC_W / 4;
    localparam int IDX_MAX = (NNIB > ID_LEN - 1) ? NNIB : ID_LEN - 1;
    localparam int IDX_W   = $clog2(IDX_MAX + 1);
    localparam int CNT_W   = ADDR_W + 1;

    localparam logic [IDX_W-1:0] LAST_BIN = IDX_W'(NBYTES - 1);
    localparam logic [IDX_W-1:0] LAST_HEX = IDX_W'(NNIB);
    localparam logic [IDX_W-1:0] LAST_ID  = IDX_W'(ID_LEN - 1);

    typedef struct packed {
        tok_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [REC_W-1:0]  rec;
        logic [IDX_W-1:0]  idx;
        logic              hexm;
        logic [7:0]        stat;
        logic              go;
        logic              halt;
        logic              clr;
    } regs_t;

    regs_t q, d;

    tok_cmd_e         cmd;
    logic [7:0]       dump_byte;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] addr_nxt;

    tokcmd_decode u_dec (
        .tok_i (host_in_data),
        .cmd_o (cmd)
    );

    tokcmd_serial #(
        .REC_W (REC_W),
        .IDX_W (IDX_W)
    ) u_ser (
        .rec_i      (q.rec),
        .idx_i      (q.idx),
        .hex_mode_i (q.hexm),
        .byte_o     (dump_byte)
    );

    assign last_idx = q.hexm ? LAST_HEX : LAST_BIN;
    assign addr_nxt = CNT_W'({1'b0, q.addr}) + CNT_W'(1);

    // next-state computation
    always_comb begin
        d      = q;
        d.go   = 1'b0;
        d.halt = 1'b0;
        d.clr  = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (host_in_valid) begin
                    case (cmd)
                        CMD_GO:   d.go   = 1'b1;
                        CMD_HALT: d.halt = 1'b1;
                        CMD_CLR:  d.clr  = 1'b1;
                        CMD_STAT: begin
                            d.stat = cap_full ? RPL_FULL : (cap_running ? RPL_RUN : RPL_IDLE);
                            d.st   = ST_STAT;
                        end
                        CMD_IDENT: begin
                            d.idx = '0;
                            d.st  = ST_IDENT;
                        end
                        CMD_DBIN, CMD_DHEX: begin
                            if (wr_count != '0) begin
                                d.cnt  = wr_count;
                                d.addr = '0;
                                d.hexm = (cmd == CMD_DHEX);
                                d.st   = ST_FETCH;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_STAT: begin
                if (host_out_ready) d.st = ST_IDLE;
            end
            ST_IDENT: begin
                if (host_out_ready) begin
                    if (q.idx == LAST_ID) d.st = ST_IDLE;
                    else d.idx = q.idx + IDX_W'(1);
                end
            end
            ST_FETCH: begin
                d.st = ST_LOAD;
            end
            ST_LOAD: begin
                d.rec = mem_rd_data;
                d.idx = '0;
                d.st  = ST_EMIT;
            end
            ST_EMIT: begin
                if (host_out_ready) begin
                    if (q.idx == last_idx) begin
                        if (addr_nxt == q.cnt) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.addr = q.addr + ADDR_W'(1);
                            d.st   = ST_FETCH;
                        end
                    end else begin
                        d.idx = q.idx + IDX_W'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // output selection
    always_comb begin
        host_out_valid = 1'b0;
        host_out_data  = 8'h00;
        case (q.st)
            ST_STAT: begin
                host_out_valid = 1'b1;
                host_out_data  = q.stat;
            end
            ST_IDENT: begin
                host_out_valid = 1'b1;
                host_out_data  = id_byte(int'(q.idx));
            end
            ST_EMIT: begin
                host_out_valid = 1'b1;
                host_out_data  = dump_byte;
            end
            default: ;
        endcase
    end

    assign host_in_ready = 1'b1;
    assign ctl_start     = q.go;
    assign ctl_stop      = q.halt;
    assign ctl_reset     = q.clr;
    assign mem_rd_en     = (q.st == ST_FETCH);
    assign mem_rd_addr   = q.addr;

    // assertions
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_out_valid && !host_out_ready) |=> (host_out_valid && $stable(host_out_data)));

    assert_onepulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_start, ctl_stop, ctl_reset}));

    assert_start_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_start |-> ($past(host_in_valid) && $past(host_in_data) == CH_GO));

    assert_rd_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (CNT_W'({1'b0, mem_rd_addr}) < q.cnt));

    assert_busy_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |-> !(ctl_start || ctl_stop || ctl_reset));

    assert_rd_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

endmodule

// File: tb/tokcmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module tokcmd_ctrl_tb_top;

    localparam int REC_W  = 32;
    localparam int ADDR_W = 4;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              host_in_valid;
    logic [7:0]        host_in_data;
    logic              host_in_ready;
    logic              host_out_valid;
    logic [7:0]        host_out_data;
    logic              host_out_ready;
    logic              cap_running;
    logic              cap_full;
    logic              ctl_start, ctl_stop, ctl_reset;
    logic [ADDR_W:0]   wr_count;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic [REC_W-1:0]  mem_rd_data;

    always #2.5 clk = ~clk;

    tokcmd_ctrl #(.REC_W(REC_W), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_in_valid(host_in_valid), .host_in_data(host_in_data), .host_in_ready(host_in_ready),
        .host_out_valid(host_out_valid), .host_out_data(host_out_data), .host_out_ready(host_out_ready),
        .cap_running(cap_running), .cap_full(cap_full),
        .ctl_start(ctl_start), .ctl_stop(ctl_stop), .ctl_reset(ctl_reset),
        .wr_count(wr_count), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data)
    );

    function automatic logic [31:0] rec_of(input int a);
        logic [31:0] av;
        av = 32'(a + 1);
        return (av * 32'h9E3779B9) ^ 32'h0F1E2D3C;
    endfunction

    // synchronous memory model, one cycle read latency
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= rec_of(int'(mem_rd_addr));
    end

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] got[$];
    logic [7:0] expq[$];
    int n_go = 0, n_halt = 0, n_clr = 0, n_rd = 0;
    int hold_err = 0, rd_err = 0;
    int exp_addr = 0, cur_cnt = 0;
    int rdy_mode = 0;
    int cyc = 0;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare the collected output with the expected stream
    task automatic cmp_stream(input string tag);
        int bad;
        bad = -1;
        if (got.size() != expq.size()) begin
            check(1'b0, {tag, " length"}, got.size(), expq.size());
        end else begin
            for (int k = 0; k < expq.size(); k++) begin
                if (bad < 0 && got[k] != expq[k]) bad = k;
            end
            if (bad >= 0) check(1'b0, {tag, " byte"}, int'(got[bad]), int'(expq[bad]));
            else check(1'b1, tag, 0, 0);
        end
    endtask

    // monitors sample away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (host_out_valid && host_out_ready) got.push_back(host_out_data);
                if (prev_stall && (!host_out_valid || host_out_data != prev_data)) hold_err++;
                prev_stall = host_out_valid && !host_out_ready;
                prev_data  = host_out_data;
                n_go   += int'(ctl_start);
                n_halt += int'(ctl_stop);
                n_clr  += int'(ctl_reset);
                if (mem_rd_en) begin
                    if (int'(mem_rd_addr) != exp_addr || exp_addr >= cur_cnt) rd_err++;
                    exp_addr++;
                    n_rd++;
                end
            end
        end
    end

    // sink ready patterns
    initial begin
        host_out_ready = 1'b1;
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            case (rdy_mode)
                0:       host_out_ready = 1'b1;
                1:       host_out_ready = cyc[0];
                default: host_out_ready = ((cyc % 5) != 2) && ((cyc % 7) != 0) && ((cyc % 11) != 4);
            endcase
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        host_in_valid = 1'b1;
        host_in_data  = b;
        @(negedge clk);
        host_in_valid = 1'b0;
    endtask

    task automatic wait_quiet();
        int qn;
        qn = 0;
        while (qn < 12) begin
            @(negedge clk);
            if (host_out_valid || mem_rd_en) qn = 0;
            else qn++;
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        int cnts[3];
        logic [7:0] cmds[2];
        logic [7:0] strb[3];
        int g0, h0, c0;
        logic [7:0] e;
        logic [31:0] r;

        cnts = '{1, 3, 16};
        cmds = '{8'h64, 8'h44};
        strb = '{8'h67, 8'h73, 8'h72};
        rst_n = 1'b0;
        host_in_valid = 1'b0;
        host_in_data = 8'h00;
        cap_running = 1'b0;
        cap_full = 1'b0;
        wr_count = '0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(!host_out_valid && !ctl_start && !ctl_stop && !ctl_reset && !mem_rd_en && host_in_ready,
              "R10 reset state", {host_out_valid, ctl_start, ctl_stop, ctl_reset, mem_rd_en, host_in_ready},
              6'b000001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 strobes, one per command, one cycle wide
        for (int s = 0; s < 3; s++) begin
            g0 = n_go; h0 = n_halt; c0 = n_clr;
            send_byte(strb[s]);
            check({ctl_start, ctl_stop, ctl_reset} == (3'b100 >> s), "R1 strobe cycle",
                  {ctl_start, ctl_stop, ctl_reset}, 3'b100 >> s);
            @(negedge clk);
            check({ctl_start, ctl_stop, ctl_reset} == 3'b000, "R1 strobe width",
                  {ctl_start, ctl_stop, ctl_reset}, 0);
            check((n_go - g0) + (n_halt - h0) + (n_clr - c0) == 1, "R1 pulse count",
                  (n_go - g0) + (n_halt - h0) + (n_clr - c0), 1);
        end

        // R2 status reply sweep
        for (int k = 0; k < 4; k++) begin
            cap_full = k[1];
            cap_running = k[0];
            rdy_mode = k % 3;
            got.delete();
            send_byte(8'h53);
            wait_quiet();
            e = cap_full ? 8'h66 : (cap_running ? 8'h72 : 8'h73);
            check(got.size() == 1 && got[0] == e, "R2 status reply",
                  (got.size() == 1) ? int'(got[0]) : -1, int'(e));
        end
        cap_full = 1'b0;
        cap_running = 1'b0;

        // R3 identification string
        rdy_mode = 2;
        got.delete();
        expq = '{8'h43, 8'h54, 8'h49, 8'h31, 8'h0A};
        send_byte(8'h69);
        wait_quiet();
        cmp_stream("R3 ident");

        // R4 / R5 dumps, with R8 injected commands and R6 read tracking
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 3; c++) begin
                rdy_mode = (m * 3 + c) % 3;
                got.delete();
                expq.delete();
                exp_addr = 0;
                n_rd = 0;
                cur_cnt = cnts[c];
                wr_count = (ADDR_W+1)'(cnts[c]);
                g0 = n_go; h0 = n_halt; c0 = n_clr;
                send_byte(cmds[m]);
                send_byte(8'h67);
                send_byte(8'h53);
                wait_quiet();
                for (int a = 0; a < cnts[c]; a++) begin
                    r = rec_of(a);
                    if (m == 0) begin
                        for (int b = 3; b >= 0; b--) expq.push_back(r[8*b +: 8]);
                    end else begin
                        for (int n = 7; n >= 0; n--)
                            expq.push_back((r[4*n +: 4] < 4'd10) ? 8'h30 + {4'h0, r[4*n +: 4]}
                                                                 : 8'h37 + {4'h0, r[4*n +: 4]});
                        expq.push_back(8'h0A);
                    end
                end
                cmp_stream(m == 0 ? "R4 binary dump" : "R5 hex dump");
                check(n_rd == cnts[c], "R6 read count", n_rd, cnts[c]);
                check(n_go == g0 && n_halt == h0 && n_clr == c0, "R8 strobes during dump",
                      (n_go - g0) + (n_halt - h0) + (n_clr - c0), 0);
            end
        end

        // R8 commands decoded again after a dump
        got.delete();
        cap_running = 1'b1;
        send_byte(8'h53);
        wait_quiet();
        check(got.size() == 1 && got[0] == 8'h72, "R8 resume after dump",
              (got.size() == 1) ? int'(got[0]) : -1, 8'h72);
        cap_running = 1'b0;

        // R6 empty dump
        got.delete();
        n_rd = 0;
        wr_count = '0;
        cur_cnt = 0;
        send_byte(8'h64);
        send_byte(8'h44);
        wait_quiet();
        check(got.size() == 0 && n_rd == 0, "R6 empty dump", got.size() + n_rd, 0);

        // R7 exhaustive sweep of non-command bytes
        got.delete();
        n_rd = 0;
        wr_count = (ADDR_W+1)'(5);
        g0 = n_go; h0 = n_halt; c0 = n_clr;
        for (int v = 0; v < 256; v++) begin
            if (v != 8'h67 && v != 8'h73 && v != 8'h72 && v != 8'h64 &&
                v != 8'h44 && v != 8'h69 && v != 8'h53) begin
                send_byte(8'(v));
            end
        end
        wait_quiet();
        check(got.size() == 0, "R7 no output", got.size(), 0);
        check(n_go == g0 && n_halt == h0 && n_clr == c0 && n_rd == 0, "R7 no strobe or read",
              (n_go - g0) + (n_halt - h0) + (n_clr - c0) + n_rd, 0);

        // R8 input ready never dropped, R9 stall stability, R6 address order
        check(host_in_ready == 1'b1, "R8 input ready", host_in_ready, 1);
        check(hold_err == 0, "R9 stall hold", hold_err, 0);
        check(rd_err == 0, "R6 read order", rd_err, 0);

        finish_run();
    end

endmodule